// File: doc/BRIEF.md
# Mirrored Two-Bank Parity Memory with Automatic Failover

This block stores data words in two identical banks, A and B, that are always written together and read together. Each bank keeps an even-parity bit beside every 16-bit word. One bank is designated prime. A read returns the prime bank's word when it checks clean. When the prime word fails its check and the other bank's word is clean, the other bank's data is returned instead and the prime role moves to that bank. One cycle later the controller repairs the faulty word by rewriting it with the good data. When both copies fail, the prime data is returned and a sticky uncorrectable flag is set.

Requests arrive on a valid/ready channel. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold its request unchanged. `req_ready` drops for exactly one cycle after a read that caused a failover, while the repair write runs. Read responses come out as a one-cycle `rsp_valid` pulse on the edge after the read is taken. The response path has no back-pressure, so the consumer must take the data when it appears. A separate injection port XORs a mask into one stored word of one bank, so that stored-bit faults can be produced on purpose. The current prime bank, a saturating failover count and the uncorrectable flag are plain status outputs.

Top module: `duplex_parity_mem`

## Requirements
- R1: Reset behaviour. After reset, bank A is prime (`prime_bank`=0), `failover_cnt` is 0, `uncorr_err` is 0, `req_ready` is 1, `rsp_valid` is 0, and every word in both banks reads as 0.
- R2: An accepted write stores the data in both banks in the same cycle, each copy with its own parity bit.
- R3: `rsp_valid` pulses for exactly one cycle, on the edge after a read is taken. An accepted write produces no response.
- R4: When the prime word passes its check, its data is returned. The prime bank, the count and the flag do not change.
- R5: When the prime word fails and the other word passes, the other word's data is returned, `prime_bank` toggles and `failover_cnt` goes up by one.
- R6: After a failover, `req_ready` is low for exactly one cycle, and the failed word is rewritten with the good data during that cycle.
- R7: When both words fail, the prime data is returned and `uncorr_err` is set. The flag stays set until reset. The prime bank and the count do not change, and no repair stall occurs.
- R8: `failover_cnt` saturates at 2^CNT_W-1 and never decreases.
- R9: Parity is even over the stored word {parity, data}, with the parity bit at bit 16. `inj_mask` bit 16 flips the parity bit and bits 15:0 flip data bits. `inj_bank`=0 selects bank A and 1 selects bank B. A mask with an even number of set bits is not detected.
- R10: A request held while `req_ready` is low is not taken and produces no response. It is taken on the first edge where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 16 | Read data |
| inj_valid | input | 1 | Apply fault mask this cycle |
| inj_bank | input | 1 | Bank to corrupt: 0 = A, 1 = B |
| inj_addr | input | 4 | Word to corrupt |
| inj_mask | input | 17 | XOR mask over {parity, data} |
| prime_bank | output | 1 | Current prime bank: 0 = A, 1 = B |
| failover_cnt | output | 4 | Saturating failover count |
| uncorr_err | output | 1 | Sticky flag: both copies failed on a read |

## Verification
A wrong prime designation shows up on the next read that has a fault in one bank. The data then comes from the corrupted copy, or the count moves when it should not. The bench compares `prime_bank` after every read, so a wrong designation is caught within one operation. A missed or misdirected repair write does not show up right away. It appears only when the surviving copy at that address is later corrupted and read, so the bench sets up that sequence on purpose. A skipped repair stall shows up in the very next request as a wrong stall count, or as a response pulse during the stall.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic { BANK_A = 1'b0, BANK_B = 1'b1 } bank_e;
  typedef enum logic [1:0] { RD_CLEAN, RD_FAILOVER, RD_DOUBLE } rd_outcome_e;
endpackage

// File: rtl/dpm_bank.sv
module dpm_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       inj_en,
  input  logic [$clog2(DEPTH)-1:0]   inj_addr,
  input  logic [DATA_W:0]            inj_mask,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = DATA_W + 1;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] new_word;

  assign new_word = {^wr_data, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((wr_en && wr_addr == AW'(i)) || (inj_en && inj_addr == AW'(i)))
          mem[i] <= ((wr_en && wr_addr == AW'(i)) ? new_word : mem[i]) ^
                    ((inj_en && inj_addr == AW'(i)) ? inj_mask : '0);
      end
    end
  end

  assign rd_data = mem[rd_addr][DATA_W-1:0];
  assign rd_ok   = ~^mem[rd_addr];

  // R2
  stored_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inj_en) |=> (~^mem[$past(wr_addr)]));
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_ok,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_ok,
  output logic              prime,
  output logic              wb_busy,
  output logic              wb_en_a,
  output logic              wb_en_b,
  output logic [AW-1:0]     wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CNT_W-1:0]  fo_cnt,
  output logic              unc
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  bank_e           prime_q, wb_bank_q;
  rd_outcome_e     outcome;
  logic [DATA_W-1:0] p_data, s_data;
  logic            p_ok, s_ok;
  logic            wb_busy_q, unc_q;
  logic [CNT_W-1:0] fo_cnt_q;

  always_comb begin
    p_data = (prime_q == BANK_B) ? b_data : a_data;
    s_data = (prime_q == BANK_B) ? a_data : b_data;
    p_ok   = (prime_q == BANK_B) ? b_ok   : a_ok;
    s_ok   = (prime_q == BANK_B) ? a_ok   : b_ok;
    if (p_ok)      outcome = RD_CLEAN;
    else if (s_ok) outcome = RD_FAILOVER;
    else           outcome = RD_DOUBLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prime_q   <= BANK_A;
      wb_bank_q <= BANK_A;
      wb_busy_q <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      fo_cnt_q  <= '0;
      unc_q     <= 1'b0;
    end else begin
      rsp_valid <= acc_rd;
      wb_busy_q <= acc_rd && (outcome == RD_FAILOVER);
      if (acc_rd) begin
        rsp_data <= (outcome == RD_FAILOVER) ? s_data : p_data;
        if (outcome == RD_FAILOVER) begin
          wb_bank_q <= prime_q;
          wb_addr   <= rd_addr;
          wb_data   <= s_data;
          prime_q   <= (prime_q == BANK_A) ? BANK_B : BANK_A;
          if (fo_cnt_q != CNT_MAX) fo_cnt_q <= fo_cnt_q + 1'b1;
        end
        if (outcome == RD_DOUBLE) unc_q <= 1'b1;
      end
    end
  end

  assign prime   = prime_q;
  assign wb_busy = wb_busy_q;
  assign wb_en_a = wb_busy_q && (wb_bank_q == BANK_A);
  assign wb_en_b = wb_busy_q && (wb_bank_q == BANK_B);
  assign fo_cnt  = fo_cnt_q;
  assign unc     = unc_q;

  // R7
  unc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unc_q |=> unc_q);
  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fo_cnt_q >= $past(fo_cnt_q));
  // R5
  prime_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_q != $past(prime_q)) |-> $past(acc_rd));
  // R6
  wb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy_q |=> !wb_busy_q);
endmodule

// File: rtl/duplex_parity_mem.sv
module duplex_parity_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(DEPTH)-1:0] req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  input  logic                     inj_valid,
  input  logic                     inj_bank,
  input  logic [$clog2(DEPTH)-1:0] inj_addr,
  input  logic [DATA_W:0]          inj_mask,
  output logic                     prime_bank,
  output logic [CNT_W-1:0]         failover_cnt,
  output logic                     uncorr_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int NB = 2;

  logic              acc, acc_wr, acc_rd, wb_busy;
  logic [NB-1:0]     wb_en;
  logic [AW-1:0]     wb_addr, bank_wr_addr;
  logic [DATA_W-1:0] wb_data, bank_wr_data;
  logic [DATA_W-1:0] rd_data [NB];
  logic [NB-1:0]     rd_ok;

  assign req_ready    = !wb_busy;
  assign acc          = req_valid && req_ready;
  assign acc_wr       = acc && req_write;
  assign acc_rd       = acc && !req_write;
  assign bank_wr_addr = wb_busy ? wb_addr : req_addr;
  assign bank_wr_data = wb_busy ? wb_data : req_wdata;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    dpm_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (acc_wr || wb_en[g]),
      .wr_addr  (bank_wr_addr),
      .wr_data  (bank_wr_data),
      .inj_en   (inj_valid && (inj_bank == 1'(g))),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask),
      .rd_addr  (req_addr),
      .rd_data  (rd_data[g]),
      .rd_ok    (rd_ok[g])
    );
  end

  dpm_ctrl #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .rd_addr   (req_addr),
    .a_data    (rd_data[0]),
    .a_ok      (rd_ok[0]),
    .b_data    (rd_data[1]),
    .b_ok      (rd_ok[1]),
    .prime     (prime_bank),
    .wb_busy   (wb_busy),
    .wb_en_a   (wb_en[0]),
    .wb_en_b   (wb_en[1]),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .fo_cnt    (failover_cnt),
    .unc       (uncorr_err)
  );

  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  // R10
  no_take_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy |=> !rsp_valid);
endmodule

// File: tb/sim_duplex_parity_mem.sv
module sim_duplex_parity_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [AW-1:0] req_addr = 0, inj_addr = 0;
  logic [DW-1:0] req_wdata = 0, rsp_data;
  logic rsp_valid, inj_valid = 0, inj_bank = 0, prime_bank, uncorr_err;
  logic [DW:0] inj_mask = 0;
  logic [CW-1:0] failover_cnt;

  int checks = 0, errors = 0;
  logic [DW:0] mA [DEPTH];
  logic [DW:0] mB [DEPTH];
  logic m_prime, m_unc, m_pend;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  duplex_parity_mem #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u0 (.*);

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [DW:0] enc(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  task automatic run_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
    logic acc = 0;
    stalls = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!acc) begin
      acc = req_ready;
      @(posedge clk); @(negedge clk);
      if (!acc) begin
        stalls++;
        chk(rsp_valid == 0, "R10 no response while stalled", rsp_valid, 0);
      end
    end
    req_valid = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int st, es;
    es = m_pend ? 1 : 0;
    run_req(1'b1, a, d, st);
    chk(st == es, "R6 stall count", st, es);
    chk(rsp_valid == 0, "R3 no response to write", rsp_valid, 0);
    mA[a] = enc(d); mB[a] = enc(d); m_pend = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    int st, es;
    logic [DW:0] pw, sw;
    logic [DW-1:0] exp;
    string rq;
    es = m_pend ? 1 : 0;
    m_pend = 0;
    pw = m_prime ? mB[a] : mA[a];
    sw = m_prime ? mA[a] : mB[a];
    if (~^pw) begin exp = pw[DW-1:0]; rq = "R4 clean read"; end
    else if (~^sw) begin
      exp = sw[DW-1:0]; rq = "R5 failover read";
      if (m_prime) mB[a] = sw; else mA[a] = sw;
      m_prime = ~m_prime;
      if (m_cnt < 15) m_cnt++;
      m_pend = 1;
    end else begin exp = pw[DW-1:0]; rq = "R7 double fault read"; m_unc = 1; end
    run_req(1'b0, a, 0, st);
    chk(st == es, "R6 stall count", st, es);
    chk(rsp_valid == 1, "R3 response pulse", rsp_valid, 1);
    chk(rsp_data == exp, {rq, " data ", tag}, rsp_data, exp);
    chk(prime_bank == m_prime, {rq, " prime"}, prime_bank, m_prime);
    chk(failover_cnt == m_cnt, {rq, " R8 count"}, failover_cnt, m_cnt);
    chk(uncorr_err == m_unc, {rq, " R7 flag"}, uncorr_err, m_unc);
  endtask

  task automatic do_inj(input logic b, input logic [AW-1:0] a, input logic [DW:0] m);
    inj_valid = 1; inj_bank = b; inj_addr = a; inj_mask = m;
    @(posedge clk); @(negedge clk);
    inj_valid = 0;
    if (b) mB[a] = mB[a] ^ m; else mA[a] = mA[a] ^ m;
    m_pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st;
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < DEPTH; i++) begin mA[i] = 0; mB[i] = 0; end
    m_prime = 0; m_unc = 0; m_pend = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(prime_bank == 0, "R1 prime A", prime_bank, 0);
    chk(failover_cnt == 0, "R1 count", failover_cnt, 0);
    chk(uncorr_err == 0, "R1 flag", uncorr_err, 0);
    chk(rsp_valid == 0, "R1 no response", rsp_valid, 0);
    do_read(4'd5, "R1 zero contents");

    // R2 + R5: write, break prime copy, secondary supplies data
    do_write(4'd3, 16'hBEEF);
    do_inj(1'b0, 4'd3, 17'h00010);
    do_read(4'd3, "R2 mirror");
    chk(prime_bank == 1, "R5 prime moved to B", prime_bank, 1);
    // R10: next request issued during the repair stall
    do_read(4'd7, "R10 held request");
    // R6: repaired copy in A survives loss of B
    do_inj(1'b1, 4'd3, 17'h08000);
    do_read(4'd3, "R6 repaired copy");
    chk(rsp_data == 16'hBEEF, "R6 repaired data", rsp_data, 16'hBEEF);
    // R9: parity-bit-only flip detected; even-weight flip undetected
    do_inj(1'b0, 4'd9, 17'h10000);
    do_read(4'd9, "R9 parity bit flip");
    do_inj(m_prime, 4'd11, 17'h00003);
    do_read(4'd11, "R9 even weight undetected");
    chk(rsp_data == 16'h0003, "R9 undetected data", rsp_data, 16'h0003);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] a = AW'($urandom_range(0, DEPTH-1));
      if (op < 4) do_write(a, DW'($urandom));
      else if (op < 8) do_read(a, "random");
      else if ($urandom_range(0, 3) != 0) do_inj(m_prime, a, 17'(1) << $urandom_range(0, DW));
      else do_inj(1'($urandom), a, 17'($urandom) | 17'h1);
    end

    // R8 saturation
    for (int n = 0; n < 20; n++) begin
      do_write(4'd0, 16'(n));
      do_inj(m_prime, 4'd0, 17'h00001);
      do_read(4'd0, "R8 saturation");
    end
    chk(failover_cnt == 4'hF, "R8 saturated", failover_cnt, 15);

    // R7 double fault
    do_write(4'd2, 16'h1234);
    do_inj(1'b0, 4'd2, 17'h00100);
    do_inj(1'b1, 4'd2, 17'h00200);
    st = prime_bank;
    do_read(4'd2, "R7 both bad");
    chk(uncorr_err == 1, "R7 flag set", uncorr_err, 1);
    chk(prime_bank == st[0], "R7 prime kept", prime_bank, st);
    do_write(4'd2, 16'h0042);
    do_read(4'd2, "R7 flag sticky");
    chk(uncorr_err == 1, "R7 flag sticky", uncorr_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule